// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Gate

This block sits in the decode stage of a two-way in-order RV32I pipeline. Each cycle it is given two instruction words that were fetched together, along with their addresses. It decides what each of the two execution pipes receives. Pipe 1 always carries the oldest instruction still waiting. Pipe 2 carries the next one in program order only when the two may run side by side. When they may not, pipe 2 receives a NOP.

A one-entry hold register keeps the instruction that could not go out. A combinational rollback output tells fetch, in the same cycle, to advance by one word instead of two. Whenever the hold register is occupied, its content goes to pipe 1, and the pairing decision is then made between the held word and the first fetched word.

Two instructions may not pair in any of these cases:
- the younger one reads a register that the older one writes;
- both touch memory;
- both change control flow;
- the younger one is of a class that only pipe 1 can execute.

A flush input empties the hold register.

Top module: `iss_dual_issue`

## Requirements
- R1: While reset is asserted and at the first edge after it, the hold register is empty (`hold_valid_o` = 0).
- R2: With the hold register empty and a pairable fetched pair: pipe 1 gets word A with `p1_sel_o`=0, pipe 2 gets word B with `p2_sel_o`=1, `hold_sel_o`=2, `rollback_o`=0, and the hold register stays empty.
- R3: With the hold register empty and an unpairable pair: pipe 1 gets word A, pipe 2 gets the NOP 32'h00000013 with address 0 and `p2_sel_o`=2, `hold_sel_o`=1, and `rollback_o`=1. Word B and its address are held and go to pipe 1 in the next cycle.
- R4: With the hold register occupied and a pairable held/A pair: pipe 1 gets the held word with `p1_sel_o`=1, pipe 2 gets word A with `p2_sel_o`=0, `hold_sel_o`=2, `rollback_o`=0, and the hold register is emptied.
- R5: With the hold register occupied and an unpairable held/A pair: pipe 1 gets the held word, pipe 2 gets the NOP with `p2_sel_o`=2, `hold_sel_o`=0, and `rollback_o`=1. Word A is held for the next cycle.
- R6: A register dependency exists when the younger word reads a source equal to the destination of the older word. A destination of x0 never creates a dependency.
- R7: Registers are decoded by opcode (bits 6:0).
  - The rd field (11:7) is written by LUI 0x37, AUIPC 0x17, JAL 0x6F, JALR 0x67, LOAD 0x03, OP-IMM 0x13 and OP 0x33.
  - The rs1 field (19:15) is read by JALR, BRANCH 0x63, LOAD, STORE 0x23, OP-IMM and OP.
  - The rs2 field (24:20) is read only by BRANCH, STORE and OP.
- R8: Two memory words (LOAD, STORE) never pair. Two control-flow words (BRANCH, JAL, JALR) never pair either.
- R9: A younger LOAD, BRANCH, JAL, JALR or multiply/divide word (OP with bits 31:25 = 0000001) never pairs. A younger STORE or plain ALU word may pair.
- R10: An asserted `flush_i` empties the hold register at the next edge. This takes priority over any capture that cycle, and the outputs of the current cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the hold register at the next edge |
| inst_a_i | input | 32 | First (older) fetched word |
| pc_a_i | input | PCW | Address of word A |
| inst_b_i | input | 32 | Second fetched word |
| pc_b_i | input | PCW | Address of word B |
| p1_inst_o | output | 32 | Word issued to pipe 1 |
| p1_pc_o | output | PCW | Address issued to pipe 1 |
| p2_inst_o | output | 32 | Word issued to pipe 2 |
| p2_pc_o | output | PCW | Address issued to pipe 2 (0 with a NOP) |
| p1_sel_o | output | 1 | Pipe 1 source: 0 word A, 1 held word |
| p2_sel_o | output | 2 | Pipe 2 source: 0 word A, 1 word B, 2 NOP |
| hold_sel_o | output | 2 | Hold capture: 0 word A, 1 word B, 2 empty |
| rollback_o | output | 1 | Fetch advances by one word instead of two |
| hold_valid_o | output | 1 | Hold register occupied |

## Verification
The bench builds the block with its defaults: 32-bit addresses, the class-based pairing limits enabled, and the standard NOP encoding. With the limits enabled, memory, control-flow and pipe-1-only conflicts can be reached alongside plain register hazards. The full 32-bit address lets the bench see whether the held address travels intact into pipe 1. Chains of back-to-back hazards keep the hold register occupied across several cycles, which exercises the path that captures word A. Flushes are applied both on a capture from empty and on a capture while occupied.

// File: rtl/iss_pkg.sv
package iss_pkg;

   localparam int unsigned ILEN = 32;
   localparam int unsigned RIDX = 5;

   localparam logic [6:0] OPC_LUI    = 7'h37;
   localparam logic [6:0] OPC_AUIPC  = 7'h17;
   localparam logic [6:0] OPC_JAL    = 7'h6f;
   localparam logic [6:0] OPC_JALR   = 7'h67;
   localparam logic [6:0] OPC_BRANCH = 7'h63;
   localparam logic [6:0] OPC_LOAD   = 7'h03;
   localparam logic [6:0] OPC_STORE  = 7'h23;
   localparam logic [6:0] OPC_OPIMM  = 7'h13;
   localparam logic [6:0] OPC_OP     = 7'h33;
   localparam logic [6:0] F7_MULDIV  = 7'h01;

   typedef enum logic [1:0] {
      SRC_FIRST  = 2'd0,
      SRC_SECOND = 2'd1,
      SRC_NOP    = 2'd2
   } slot_src_e;

   typedef struct packed {
      logic            wr_rd;
      logic [RIDX-1:0] rd;
      logic            rd_rs1;
      logic [RIDX-1:0] rs1;
      logic            rd_rs2;
      logic [RIDX-1:0] rs2;
      logic            is_mem;
      logic            is_ctl;
      logic            p1_only;
   } ins_info_t;

endpackage

// File: rtl/iss_decode.sv
module iss_decode
   import iss_pkg::*;
(
   input  logic [ILEN-1:0] inst_i,
   output ins_info_t       info_o
);
   logic [6:0] opc;
   logic       unused_funct3;

   assign opc           = inst_i[6:0];
   assign unused_funct3 = ^inst_i[14:12];

   always_comb begin
      info_o     = '0;
      info_o.rd  = inst_i[11:7];
      info_o.rs1 = inst_i[19:15];
      info_o.rs2 = inst_i[24:20];
      unique case (opc)
         OPC_LUI, OPC_AUIPC: info_o.wr_rd = 1'b1;
         OPC_JAL: begin
            info_o.wr_rd   = 1'b1;
            info_o.is_ctl  = 1'b1;
            info_o.p1_only = 1'b1;
         end
         OPC_JALR: begin
            info_o.wr_rd   = 1'b1;
            info_o.rd_rs1  = 1'b1;
            info_o.is_ctl  = 1'b1;
            info_o.p1_only = 1'b1;
         end
         OPC_BRANCH: begin
            info_o.rd_rs1  = 1'b1;
            info_o.rd_rs2  = 1'b1;
            info_o.is_ctl  = 1'b1;
            info_o.p1_only = 1'b1;
         end
         OPC_LOAD: begin
            info_o.wr_rd   = 1'b1;
            info_o.rd_rs1  = 1'b1;
            info_o.is_mem  = 1'b1;
            info_o.p1_only = 1'b1;
         end
         OPC_STORE: begin
            info_o.rd_rs1 = 1'b1;
            info_o.rd_rs2 = 1'b1;
            info_o.is_mem = 1'b1;
         end
         OPC_OPIMM: begin
            info_o.wr_rd  = 1'b1;
            info_o.rd_rs1 = 1'b1;
         end
         OPC_OP: begin
            info_o.wr_rd   = 1'b1;
            info_o.rd_rs1  = 1'b1;
            info_o.rd_rs2  = 1'b1;
            info_o.p1_only = (inst_i[31:25] == F7_MULDIV);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/iss_pair_check.sv
module iss_pair_check
   import iss_pkg::*;
#(
   parameter bit PAIR_LIMITS = 1'b1
) (
   input  ins_info_t older_i,
   input  ins_info_t younger_i,
   output logic      pairable_o
);
   logic raw_hit;
   logic class_clash;
   logic unused_info;

   assign unused_info = ^{older_i, younger_i};

   assign raw_hit = older_i.wr_rd && (older_i.rd != '0) &&
                    ((younger_i.rd_rs1 && (younger_i.rs1 == older_i.rd)) ||
                     (younger_i.rd_rs2 && (younger_i.rs2 == older_i.rd)));

   generate
      if (PAIR_LIMITS) begin : g_limits
         assign class_clash = (older_i.is_mem && younger_i.is_mem) ||
                              (older_i.is_ctl && younger_i.is_ctl) ||
                              younger_i.p1_only;
      end else begin : g_hazard_only
         assign class_clash = 1'b0;
      end
   endgenerate

   assign pairable_o = !raw_hit && !class_clash;
endmodule

// File: rtl/iss_hold_reg.sv
module iss_hold_reg
   import iss_pkg::*;
#(
   parameter int unsigned     PCW      = 32,
   parameter logic [ILEN-1:0] NOP_WORD = 32'h0000_0013
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            load_i,
   input  logic [ILEN-1:0] ld_inst_i,
   input  logic [PCW-1:0]  ld_pc_i,
   output logic            valid_o,
   output logic [ILEN-1:0] inst_o,
   output logic [PCW-1:0]  pc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         inst_o  <= NOP_WORD;
         pc_o    <= '0;
      end else begin
         valid_o <= load_i && !flush_i;
         if (load_i) begin
            inst_o <= ld_inst_i;
            pc_o   <= ld_pc_i;
         end
      end
   end
endmodule

// File: rtl/iss_dual_issue.sv
module iss_dual_issue
   import iss_pkg::*;
#(
   parameter int unsigned     PCW         = 32,
   parameter bit              PAIR_LIMITS = 1'b1,
   parameter logic [ILEN-1:0] NOP_WORD    = 32'h0000_0013
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [ILEN-1:0]  inst_a_i,
   input  logic [PCW-1:0]   pc_a_i,
   input  logic [ILEN-1:0]  inst_b_i,
   input  logic [PCW-1:0]   pc_b_i,
   output logic [ILEN-1:0]  p1_inst_o,
   output logic [PCW-1:0]   p1_pc_o,
   output logic [ILEN-1:0]  p2_inst_o,
   output logic [PCW-1:0]   p2_pc_o,
   output logic             p1_sel_o,
   output logic [1:0]       p2_sel_o,
   output logic [1:0]       hold_sel_o,
   output logic             rollback_o,
   output logic             hold_valid_o
);
   localparam int unsigned NSLOT = 2;

   generate
      if (PCW < 2 || PCW > 64) begin : g_bad_pcw
         $error("iss_dual_issue: PCW must lie in 2..64");
      end
      if (NOP_WORD[6:0] != OPC_OPIMM) begin : g_bad_nop
         $error("iss_dual_issue: NOP_WORD must be an OP-IMM encoding");
      end
   endgenerate

   logic            hold_v;
   logic [ILEN-1:0] hold_inst;
   logic [PCW-1:0]  hold_pc;

   logic [ILEN-1:0] slot_inst [NSLOT];
   ins_info_t       slot_info [NSLOT];
   logic            pairable;

   slot_src_e       p2_src;
   slot_src_e       hold_src;
   logic            hold_load;
   logic [ILEN-1:0] hold_nxt_inst;
   logic [PCW-1:0]  hold_nxt_pc;

   // slot 0 is the older word, slot 1 the younger
   assign slot_inst[0] = hold_v ? hold_inst : inst_a_i;
   assign slot_inst[1] = hold_v ? inst_a_i  : inst_b_i;

   for (genvar s = 0; s < NSLOT; s++) begin : g_dec
      iss_decode u_dec (
         .inst_i (slot_inst[s]),
         .info_o (slot_info[s])
      );
   end

   iss_pair_check #(.PAIR_LIMITS(PAIR_LIMITS)) u_pair (
      .older_i    (slot_info[0]),
      .younger_i  (slot_info[1]),
      .pairable_o (pairable)
   );

   always_comb begin
      if (pairable) begin
         p2_src   = hold_v ? SRC_FIRST : SRC_SECOND;
         hold_src = SRC_NOP;
      end else begin
         p2_src   = SRC_NOP;
         hold_src = hold_v ? SRC_FIRST : SRC_SECOND;
      end
   end

   assign p1_sel_o   = hold_v;
   assign p2_sel_o   = p2_src;
   assign hold_sel_o = hold_src;
   assign rollback_o = !pairable;

   assign p1_inst_o = hold_v ? hold_inst : inst_a_i;
   assign p1_pc_o   = hold_v ? hold_pc   : pc_a_i;

   always_comb begin
      unique case (p2_src)
         SRC_FIRST:  begin p2_inst_o = inst_a_i; p2_pc_o = pc_a_i; end
         SRC_SECOND: begin p2_inst_o = inst_b_i; p2_pc_o = pc_b_i; end
         default:    begin p2_inst_o = NOP_WORD; p2_pc_o = '0;     end
      endcase
   end

   always_comb begin
      hold_load     = (hold_src != SRC_NOP);
      hold_nxt_inst = (hold_src == SRC_FIRST) ? inst_a_i : inst_b_i;
      hold_nxt_pc   = (hold_src == SRC_FIRST) ? pc_a_i   : pc_b_i;
   end

   iss_hold_reg #(.PCW(PCW), .NOP_WORD(NOP_WORD)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .load_i    (hold_load),
      .ld_inst_i (hold_nxt_inst),
      .ld_pc_i   (hold_nxt_pc),
      .valid_o   (hold_v),
      .inst_o    (hold_inst),
      .pc_o      (hold_pc)
   );

   assign hold_valid_o = hold_v;
endmodule

// File: rtl/iss_dual_issue_chk.sv
module iss_dual_issue_chk #(
   parameter int unsigned PCW      = 32,
   parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
   input logic           clk,
   input logic           rst_n,
   input logic           flush_i,
   input logic [31:0]    inst_a_i,
   input logic [PCW-1:0] pc_a_i,
   input logic [31:0]    inst_b_i,
   input logic [PCW-1:0] pc_b_i,
   input logic [31:0]    p1_inst_o,
   input logic [PCW-1:0] p1_pc_o,
   input logic [31:0]    p2_inst_o,
   input logic [1:0]     p2_sel_o,
   input logic           rollback_o,
   input logic           hold_valid_o
);
   AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !hold_valid_o); // R1

   AST_PAIR_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !rollback_o |=> !hold_valid_o); // R2

   AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rollback_o && !flush_i && !hold_valid_o) |=>
      (hold_valid_o && p1_inst_o == $past(inst_b_i) && p1_pc_o == $past(pc_b_i))); // R3

   AST_NOP_ON_P2: assert property (@(posedge clk) disable iff (!rst_n)
      (p2_sel_o == 2'd2) |-> (p2_inst_o == NOP_WORD && rollback_o)); // R3

   AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
      (rollback_o && !flush_i && hold_valid_o) |=>
      (hold_valid_o && p1_inst_o == $past(inst_a_i) && p1_pc_o == $past(pc_a_i))); // R5

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !hold_valid_o); // R10
endmodule

bind iss_dual_issue iss_dual_issue_chk #(.PCW(PCW), .NOP_WORD(NOP_WORD)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush_i      (flush_i),
   .inst_a_i     (inst_a_i),
   .pc_a_i       (pc_a_i),
   .inst_b_i     (inst_b_i),
   .pc_b_i       (pc_b_i),
   .p1_inst_o    (p1_inst_o),
   .p1_pc_o      (p1_pc_o),
   .p2_inst_o    (p2_inst_o),
   .p2_sel_o     (p2_sel_o),
   .rollback_o   (rollback_o),
   .hold_valid_o (hold_valid_o)
);

// File: tb/tb_iss_dual_issue.sv
`timescale 1ns/100ps
module tb_iss_dual_issue;
   localparam int unsigned PCW = 32;
   localparam logic [31:0] NOP = 32'h0000_0013;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 1'b0;
   logic [31:0] inst_a_i = NOP, inst_b_i = NOP;
   logic [PCW-1:0] pc_a_i = '0, pc_b_i = '0;
   logic [31:0] p1_inst_o, p2_inst_o;
   logic [PCW-1:0] p1_pc_o, p2_pc_o;
   logic p1_sel_o, rollback_o, hold_valid_o;
   logic [1:0] p2_sel_o, hold_sel_o;

   always #2.5 clk = ~clk;

   iss_dual_issue dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .inst_a_i(inst_a_i), .pc_a_i(pc_a_i), .inst_b_i(inst_b_i), .pc_b_i(pc_b_i),
      .p1_inst_o(p1_inst_o), .p1_pc_o(p1_pc_o), .p2_inst_o(p2_inst_o), .p2_pc_o(p2_pc_o),
      .p1_sel_o(p1_sel_o), .p2_sel_o(p2_sel_o), .hold_sel_o(hold_sel_o),
      .rollback_o(rollback_o), .hold_valid_o(hold_valid_o)
   );

   typedef struct {
      logic [31:0] p1i; logic [31:0] p1p; logic [31:0] p2i; logic [31:0] p2p;
      logic p1s; logic [1:0] p2s; logic [1:0] hs; logic rb; logic hv; string tag;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;

   // reference hold state, kept from the requirements
   logic        m_hv = 1'b0;
   logic [31:0] m_hi = NOP;
   logic [31:0] m_hp = '0;
   logic [31:0] pc = 32'h0000_1000;

   function automatic logic wr_rd(input logic [31:0] i);
      logic [6:0] o = i[6:0];
      return (o == 7'h37 || o == 7'h17 || o == 7'h6f || o == 7'h67 ||
              o == 7'h03 || o == 7'h13 || o == 7'h33) && (i[11:7] != 5'd0);
   endfunction
   function automatic logic uses1(input logic [31:0] i);
      logic [6:0] o = i[6:0];
      return o == 7'h67 || o == 7'h63 || o == 7'h03 || o == 7'h23 || o == 7'h13 || o == 7'h33;
   endfunction
   function automatic logic uses2(input logic [31:0] i);
      logic [6:0] o = i[6:0];
      return o == 7'h63 || o == 7'h23 || o == 7'h33;
   endfunction
   function automatic logic memw(input logic [31:0] i);
      return i[6:0] == 7'h03 || i[6:0] == 7'h23;
   endfunction
   function automatic logic ctlw(input logic [31:0] i);
      return i[6:0] == 7'h63 || i[6:0] == 7'h6f || i[6:0] == 7'h67;
   endfunction
   function automatic logic pipe1w(input logic [31:0] i);
      return i[6:0] == 7'h03 || ctlw(i) || (i[6:0] == 7'h33 && i[31:25] == 7'h01);
   endfunction
   function automatic logic can_pair(input logic [31:0] o, input logic [31:0] y);
      logic dep = wr_rd(o) && ((uses1(y) && y[19:15] == o[11:7]) ||
                               (uses2(y) && y[24:20] == o[11:7]));
      return !dep && !(memw(o) && memw(y)) && !(ctlw(o) && ctlw(y)) && !pipe1w(y);
   endfunction

   function automatic logic [31:0] addi(input int rd, input int rs1, input int imm);
      return {imm[11:0], rs1[4:0], 3'b000, rd[4:0], 7'h13};
   endfunction
   function automatic logic [31:0] add(input int rd, input int rs1, input int rs2);
      return {7'h00, rs2[4:0], rs1[4:0], 3'b000, rd[4:0], 7'h33};
   endfunction
   function automatic logic [31:0] mul(input int rd, input int rs1, input int rs2);
      return {7'h01, rs2[4:0], rs1[4:0], 3'b000, rd[4:0], 7'h33};
   endfunction
   function automatic logic [31:0] lw(input int rd, input int rs1);
      return {12'h000, rs1[4:0], 3'b010, rd[4:0], 7'h03};
   endfunction
   function automatic logic [31:0] sw(input int rs2, input int rs1);
      return {7'h00, rs2[4:0], rs1[4:0], 3'b010, 5'd0, 7'h23};
   endfunction
   function automatic logic [31:0] beq(input int rs1, input int rs2);
      return {7'h00, rs2[4:0], rs1[4:0], 3'b000, 5'd0, 7'h63};
   endfunction
   function automatic logic [31:0] jal(input int rd);
      return {20'h00000, rd[4:0], 7'h6f};
   endfunction
   function automatic logic [31:0] lui(input int rd);
      return {20'h12345, rd[4:0], 7'h37};
   endfunction

   // driver: applies one fetched pair and queues what the ports must show
   task automatic step(input logic [31:0] a, input logic [31:0] b, input logic fl,
                       input string tag);
      exp_t e;
      logic ok;
      @(negedge clk);
      inst_a_i = a; inst_b_i = b; pc_a_i = pc; pc_b_i = pc + 32'd4; flush_i = fl;
      e.tag = tag;
      e.hv  = m_hv;
      if (m_hv) begin
         ok = can_pair(m_hi, a);
         e.p1i = m_hi; e.p1p = m_hp; e.p1s = 1'b1;
         e.p2i = ok ? a : NOP; e.p2p = ok ? pc : '0; e.p2s = ok ? 2'd0 : 2'd2;
         e.hs  = ok ? 2'd2 : 2'd0;
         if (!ok) begin m_hi = a; m_hp = pc; end
      end else begin
         ok = can_pair(a, b);
         e.p1i = a; e.p1p = pc; e.p1s = 1'b0;
         e.p2i = ok ? b : NOP; e.p2p = ok ? pc + 32'd4 : '0; e.p2s = ok ? 2'd1 : 2'd2;
         e.hs  = ok ? 2'd2 : 2'd1;
         if (!ok) begin m_hi = b; m_hp = pc + 32'd4; end
      end
      e.rb = !ok;
      m_hv = !ok && !fl;
      q.push_back(e);
      pc = pc + 32'd8;
   endtask

   // monitor: compares the ports 1 ns after the driver's falling edge
   always @(negedge clk) begin
      exp_t e;
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         total++;
         if (p1_inst_o !== e.p1i || p1_pc_o !== e.p1p || p2_inst_o !== e.p2i ||
             p2_pc_o !== e.p2p || p1_sel_o !== e.p1s || p2_sel_o !== e.p2s ||
             hold_sel_o !== e.hs || rollback_o !== e.rb || hold_valid_o !== e.hv) begin
            bad++;
            $display("FAIL %s: act p1=%h/%h p2=%h/%h sel=%0d/%0d/%0d rb=%0d hv=%0d exp p1=%h/%h p2=%h/%h sel=%0d/%0d/%0d rb=%0d hv=%0d",
                     e.tag, p1_inst_o, p1_pc_o, p2_inst_o, p2_pc_o, p1_sel_o, p2_sel_o,
                     hold_sel_o, rollback_o, hold_valid_o, e.p1i, e.p1p, e.p2i, e.p2p,
                     e.p1s, e.p2s, e.hs, e.rb, e.hv);
         end
      end
   end

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (hold_valid_o !== 1'b0) begin
         bad++;
         $display("FAIL R1: act hv=%0d exp hv=0", hold_valid_o);
      end
      rst_n = 1'b1;
      step(addi(1, 0, 5), addi(2, 0, 6), 1'b0, "R1");
      step(addi(3, 0, 1), add(4, 1, 2), 1'b0, "R2");
      step(add(3, 1, 2), add(4, 3, 0), 1'b0, "R3");
      step(add(5, 4, 1), addi(9, 0, 0), 1'b0, "R5");
      step(addi(6, 0, 1), addi(9, 0, 0), 1'b0, "R4");
      step(addi(7, 1, 1), addi(8, 0, 2), 1'b0, "R2");
      step(addi(0, 1, 1), add(7, 0, 0), 1'b0, "R6");
      step(lui(8), addi(9, 1, 8), 1'b0, "R7");
      step(addi(2, 0, 3), sw(2, 1), 1'b0, "R7");
      step(addi(9, 0, 0), addi(10, 0, 0), 1'b0, "R4");
      step(sw(1, 2), lw(10, 3), 1'b0, "R8");
      step(addi(11, 0, 0), addi(12, 0, 0), 1'b0, "R4");
      step(addi(12, 0, 0), beq(0, 0), 1'b0, "R9");
      step(jal(0), addi(13, 0, 0), 1'b0, "R8");
      step(addi(13, 0, 0), addi(14, 0, 0), 1'b0, "R4");
      step(addi(14, 0, 0), mul(15, 1, 2), 1'b0, "R9");
      step(addi(16, 0, 0), addi(17, 0, 0), 1'b0, "R4");
      step(addi(18, 0, 0), sw(1, 2), 1'b0, "R9");
      step(addi(18, 1, 0), lw(19, 2), 1'b0, "R9");
      step(addi(20, 0, 0), addi(21, 0, 0), 1'b0, "R4");
      step(addi(14, 0, 0), add(15, 14, 0), 1'b1, "R10");
      step(addi(16, 0, 0), addi(17, 0, 0), 1'b0, "R10");
      step(add(22, 1, 1), add(23, 22, 0), 1'b0, "R3");
      step(add(24, 23, 0), addi(25, 0, 0), 1'b1, "R10");
      step(addi(26, 0, 0), addi(27, 0, 0), 1'b0, "R10");
      @(negedge clk);
      flush_i = 1'b0;
      #2;
      if (q.size() != 0) begin
         bad++;
         total++;
         $display("FAIL scoreboard: act left=%0d exp left=0", q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule